// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store placed between a direct-mapped cache and the next memory level. It keeps lines that the cache has thrown out. When the cache misses, it presents the missing line address to the buffer together with the line it is about to displace. All stored line addresses are compared at once. On a match the stored line goes back to the cache and the displaced line takes over the same entry, so the two lines trade places. When nothing matches, the request address goes on to the lower level and the displaced line is kept in the buffer.

Each entry holds a whole line, its line address (the address bits above the byte offset) and a dirty flag. When the buffer is full, a new line takes the place of the entry that was written least recently. If that older line is dirty, it goes out on a write-back port. A flush input drops every entry in a single cycle. The entry count, the address width, the line size and the order in which free entries are filled are all parameters.

Top module: `victim_buffer`

## Requirements
- R1: After reset no response and no write-back is signalled, and every entry is empty.
- R2: A request accepted without flush produces exactly one of `rsp_hit_o` / `rsp_miss_o` in the following cycle. In a cycle that follows no accepted request, both are low.
- R3: A request hits when a valid entry holds the requested line address. The response then carries that entry's line on `rsp_line_o` and its dirty flag on `rsp_dirty_o`.
- R4: On a hit with `ev_valid_i` high, the displaced line (address, data, dirty flag) replaces the hit line in the same entry, and a later request finds it there. On a hit with `ev_valid_i` low, the hit entry is emptied.
- R5: On a miss, `fwd_tag_o` carries the requested line address in the response cycle.
- R6: On a miss with `ev_valid_i` high while an entry is free, the displaced line goes into a free entry and no write-back occurs.
- R7: On a miss with `ev_valid_i` high while all entries are full, the displaced line replaces the entry written least recently (writes are inserts and swaps). If that entry is dirty, `wb_valid_o` pulses with its address and data in the response cycle. If it is clean, no write-back occurs.
- R8: A miss with `ev_valid_i` low leaves the stored contents unchanged and produces no write-back.
- R9: `flush_i` empties every entry without any write-back. A request in the same cycle as a flush is ignored and gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty all entries |
| req_valid_i | input | 1 | Lookup request (the cache missed) |
| req_tag_i | input | TAG_W (27) | Requested line address |
| ev_valid_i | input | 1 | The cache is displacing a valid line |
| ev_tag_i | input | TAG_W (27) | Line address of the displaced line |
| ev_line_i | input | LINE_W (256) | Data of the displaced line |
| ev_dirty_i | input | 1 | Dirty flag of the displaced line |
| rsp_hit_o | output | 1 | The request hit in the buffer |
| rsp_miss_o | output | 1 | The request missed in the buffer |
| rsp_line_o | output | LINE_W (256) | Line returned on a hit |
| rsp_dirty_o | output | 1 | Dirty flag of the returned line |
| fwd_tag_o | output | TAG_W (27) | Line address forwarded to the lower level on a miss |
| wb_valid_o | output | 1 | A dirty line was pushed out |
| wb_tag_o | output | TAG_W (27) | Line address of the written-back line |
| wb_line_o | output | LINE_W (256) | Data of the written-back line |

## Verification
The assertions check on every cycle the following. A request is answered in the next cycle with exactly one of hit or miss, and idle cycles stay silent. No more than one entry matches a request. The recency ranks stay a permutation, so there is always exactly one replacement candidate. A write-back comes only with a miss. The forwarded address equals the previous request. A flush leaves no valid entry. Other behaviour only the bench's scenarios can show, because it needs a model of the buffer's contents: which line is chosen as the oldest, that a swapped-in line can be found again with the right data and dirty flag, that a hit without a displaced line empties its entry, and that a request made together with a flush is dropped.

// File: rtl/vb_pkg.sv
package vb_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_FLUSH = 2'd1,
      OP_HIT   = 2'd2,
      OP_MISS  = 2'd3
   } vb_op_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
   parameter int N     = 4,
   parameter int TAG_W = 27,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     lookup_i,
   input  logic [N-1:0]             valid_i,
   input  logic [N-1:0][TAG_W-1:0]  tags_i,
   input  logic [TAG_W-1:0]         key_i,
   output logic [N-1:0]             hit_vec_o,
   output logic                     hit_o,
   output logic [IDX_W-1:0]         hit_idx_o
);
   // one comparator per entry
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == key_i);
   end

   assign hit_o = |hit_vec_o;

   always_comb begin
      hit_idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec_o[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
      end
   end

   // R3
   single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lookup_i |-> $onehot0(hit_vec_o));
endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
   parameter int N = 4,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             touch_i,
   input  logic [IDX_W-1:0] touch_idx_i,
   output logic [IDX_W-1:0] lru_idx_o
);
   // rank 0 = written most recently, rank N-1 = oldest
   logic [IDX_W-1:0] rank_q [N];
   logic [N-1:0]     oldest_vec;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
      end else if (touch_i) begin
         for (int i = 0; i < N; i++) begin
            if (IDX_W'(i) == touch_idx_i)
               rank_q[i] <= '0;
            else if (rank_q[i] < rank_q[touch_idx_i])
               rank_q[i] <= rank_q[i] + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_old
      assign oldest_vec[g] = (rank_q[g] == IDX_W'(N - 1));
   end

   always_comb begin
      lru_idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (oldest_vec[i]) lru_idx_o = IDX_W'(i);
      end
   end

   // R7
   one_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(oldest_vec));
endmodule

// File: rtl/vb_alloc.sv
module vb_alloc #(
   parameter int N             = 4,
   parameter bit FILL_FROM_LOW = 1'b1,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     valid_i,
   input  logic [IDX_W-1:0] lru_idx_i,
   output logic [IDX_W-1:0] slot_o,
   output logic             slot_busy_o
);
   logic [IDX_W-1:0] free_idx;
   logic             any_free;

   assign any_free = ~&valid_i;

   if (FILL_FROM_LOW) begin : g_low
      always_comb begin
         free_idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         free_idx = '0;
         for (int i = 0; i < N; i++) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
         end
      end
   end

   assign slot_o      = any_free ? free_idx : lru_idx_i;
   assign slot_busy_o = !any_free;
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
   parameter int ADDR_W        = 32,
   parameter int LINE_BYTES    = 32,
   parameter int ENTRIES       = 4,
   parameter bit FILL_FROM_LOW = 1'b1,
   localparam int OFFS_W = $clog2(LINE_BYTES),
   localparam int TAG_W  = ADDR_W - OFFS_W,
   localparam int LINE_W = 8 * LINE_BYTES,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              flush_i,
   input  logic              req_valid_i,
   input  logic [TAG_W-1:0]  req_tag_i,
   input  logic              ev_valid_i,
   input  logic [TAG_W-1:0]  ev_tag_i,
   input  logic [LINE_W-1:0] ev_line_i,
   input  logic              ev_dirty_i,
   output logic              rsp_hit_o,
   output logic              rsp_miss_o,
   output logic [LINE_W-1:0] rsp_line_o,
   output logic              rsp_dirty_o,
   output logic [TAG_W-1:0]  fwd_tag_o,
   output logic              wb_valid_o,
   output logic [TAG_W-1:0]  wb_tag_o,
   output logic [LINE_W-1:0] wb_line_o
);
   import vb_pkg::*;

   initial begin
      if (ENTRIES < 2)
         $error("victim_buffer: ENTRIES must be at least 2");
      if ((1 << OFFS_W) != LINE_BYTES)
         $error("victim_buffer: LINE_BYTES must be a power of two");
      if (OFFS_W >= ADDR_W)
         $error("victim_buffer: line offset leaves no address bits");
   end

   logic [ENTRIES-1:0]            valid_q;
   logic [ENTRIES-1:0]            dirty_q;
   logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
   logic [LINE_W-1:0]             line_q [ENTRIES];

   logic [ENTRIES-1:0] hit_vec;
   logic               hit;
   logic [IDX_W-1:0]   hit_idx;
   logic [IDX_W-1:0]   lru_idx;
   logic [IDX_W-1:0]   slot_idx;
   logic               slot_busy;
   logic               lookup;
   logic [ENTRIES-1:0] wr_en;
   logic               touch;
   logic [IDX_W-1:0]   touch_idx;
   logic               push_dirty;
   vb_op_e             op;

   assign lookup = req_valid_i && !flush_i;

   vb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_match (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lookup_i  (lookup),
      .valid_i   (valid_q),
      .tags_i    (tag_q),
      .key_i     (req_tag_i),
      .hit_vec_o (hit_vec),
      .hit_o     (hit),
      .hit_idx_o (hit_idx)
   );

   vb_lru #(.N(ENTRIES)) u_lru (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .touch_i     (touch),
      .touch_idx_i (touch_idx),
      .lru_idx_o   (lru_idx)
   );

   vb_alloc #(.N(ENTRIES), .FILL_FROM_LOW(FILL_FROM_LOW)) u_alloc (
      .valid_i     (valid_q),
      .lru_idx_i   (lru_idx),
      .slot_o      (slot_idx),
      .slot_busy_o (slot_busy)
   );

   always_comb begin
      if (flush_i)          op = OP_FLUSH;
      else if (!req_valid_i) op = OP_IDLE;
      else if (hit)         op = OP_HIT;
      else                  op = OP_MISS;
   end

   // per-entry write enable for an incoming displaced line
   for (genvar g = 0; g < ENTRIES; g++) begin : g_wr
      assign wr_en[g] = ev_valid_i &&
         (((op == OP_HIT)  && (hit_idx  == IDX_W'(g))) ||
          ((op == OP_MISS) && (slot_idx == IDX_W'(g))));
   end

   assign touch      = |wr_en;
   assign touch_idx  = (op == OP_HIT) ? hit_idx : slot_idx;
   assign push_dirty = (op == OP_MISS) && ev_valid_i && slot_busy && dirty_q[slot_idx];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= '0;
      end else if (op == OP_FLUSH) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en[i])
               valid_q[i] <= 1'b1;
            else if ((op == OP_HIT) && (hit_idx == IDX_W'(i)))
               valid_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (wr_en[i]) begin
            tag_q[i]   <= ev_tag_i;
            line_q[i]  <= ev_line_i;
            dirty_q[i] <= ev_dirty_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_hit_o   <= 1'b0;
         rsp_miss_o  <= 1'b0;
         rsp_line_o  <= '0;
         rsp_dirty_o <= 1'b0;
         fwd_tag_o   <= '0;
         wb_valid_o  <= 1'b0;
         wb_tag_o    <= '0;
         wb_line_o   <= '0;
      end else begin
         rsp_hit_o  <= (op == OP_HIT);
         rsp_miss_o <= (op == OP_MISS);
         wb_valid_o <= push_dirty;
         if (op == OP_HIT) begin
            rsp_line_o  <= line_q[hit_idx];
            rsp_dirty_o <= dirty_q[hit_idx];
         end
         if (op == OP_MISS) fwd_tag_o <= req_tag_i;
         if (push_dirty) begin
            wb_tag_o  <= tag_q[slot_idx];
            wb_line_o <= line_q[slot_idx];
         end
      end
   end

   // R2
   answer_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lookup |=> (rsp_hit_o ^ rsp_miss_o));
   // R2
   quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lookup |=> !(rsp_hit_o || rsp_miss_o));
   // R5
   fwd_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_miss_o |-> (fwd_tag_o == $past(req_tag_i)));
   // R7
   wb_only_on_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_valid_o |-> rsp_miss_o);
   // R9
   flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (valid_q == '0) && !wb_valid_o);
endmodule

// File: tb/sim_victim_buffer.sv
`timescale 1ns/1ps
module sim_victim_buffer;
   localparam int TAG_W  = 27;
   localparam int LINE_W = 256;
   localparam int NE     = 4;
   localparam int POOL   = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic              req_valid = 1'b0;
   logic [TAG_W-1:0]  req_tag = '0;
   logic              ev_valid = 1'b0;
   logic [TAG_W-1:0]  ev_tag = '0;
   logic [LINE_W-1:0] ev_line = '0;
   logic              ev_dirty = 1'b0;
   logic              rsp_hit, rsp_miss, rsp_dirty, wb_valid;
   logic [LINE_W-1:0] rsp_line, wb_line;
   logic [TAG_W-1:0]  fwd_tag, wb_tag;

   always #2 clk = ~clk;

   victim_buffer u0 (
      .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
      .req_valid_i(req_valid), .req_tag_i(req_tag),
      .ev_valid_i(ev_valid), .ev_tag_i(ev_tag), .ev_line_i(ev_line), .ev_dirty_i(ev_dirty),
      .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss), .rsp_line_o(rsp_line), .rsp_dirty_o(rsp_dirty),
      .fwd_tag_o(fwd_tag), .wb_valid_o(wb_valid), .wb_tag_o(wb_tag), .wb_line_o(wb_line)
   );

   // reference model: slot positions are the bench's own
   bit                m_v  [NE];
   logic [TAG_W-1:0]  m_t  [NE];
   logic [LINE_W-1:0] m_d  [NE];
   bit                m_dy [NE];
   int                m_st [NE];
   int                stamp = 0;
   logic [TAG_W-1:0]  pool [POOL];

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int mfind(input logic [TAG_W-1:0] t);
      for (int i = 0; i < NE; i++) if (m_v[i] && m_t[i] == t) return i;
      return -1;
   endfunction

   function automatic int mslot();
      int best = 0;
      for (int i = 0; i < NE; i++) if (!m_v[i]) return i;
      for (int i = 1; i < NE; i++) if (m_st[i] < m_st[best]) best = i;
      return best;
   endfunction

   function automatic logic [LINE_W-1:0] rand_line();
      logic [LINE_W-1:0] l;
      for (int i = 0; i < LINE_W / 32; i++) l[i*32 +: 32] = $urandom;
      return l;
   endfunction

   task automatic mstore(input int s, input logic [TAG_W-1:0] t,
                         input logic [LINE_W-1:0] d, input bit dy);
      m_v[s] = 1'b1; m_t[s] = t; m_d[s] = d; m_dy[s] = dy;
      stamp++;
      m_st[s] = stamp;
   endtask

   // one request; starts and ends at a falling edge
   task automatic lookup(input logic [TAG_W-1:0] t, input bit ev,
                         input logic [TAG_W-1:0] et, input bit edy);
      int h, s;
      bit exp_wb;
      logic [LINE_W-1:0] ed;
      ed = rand_line();
      h  = mfind(t);
      s  = mslot();
      req_valid = 1'b1; req_tag = t;
      ev_valid = ev; ev_tag = et; ev_line = ed; ev_dirty = edy;
      @(negedge clk);
      req_valid = 1'b0; ev_valid = 1'b0;
      if (h >= 0) begin
         check(rsp_hit && !rsp_miss, "R3", "hit flag", {254'd0, rsp_hit, rsp_miss}, 256'd2);
         check(rsp_line == m_d[h], "R3", "hit line", rsp_line, m_d[h]);
         check(rsp_dirty == m_dy[h], "R3", "hit dirty", 256'(rsp_dirty), 256'(m_dy[h]));
         check(!wb_valid, "R4", "no write-back on hit", 256'(wb_valid), 256'd0);
         if (ev) mstore(h, et, ed, edy);
         else    m_v[h] = 1'b0;
      end else begin
         check(rsp_miss && !rsp_hit, "R2", "miss flag", {254'd0, rsp_hit, rsp_miss}, 256'd1);
         check(fwd_tag == t, "R5", "forwarded tag", 256'(fwd_tag), 256'(t));
         if (ev) begin
            exp_wb = m_v[s] && m_dy[s];
            if (!m_v[s])
               check(!wb_valid, "R6", "no write-back into free entry", 256'(wb_valid), 256'd0);
            else begin
               check(wb_valid == exp_wb, "R7", "write-back flag", 256'(wb_valid), 256'(exp_wb));
               if (exp_wb) begin
                  check(wb_tag == m_t[s], "R7", "write-back tag", 256'(wb_tag), 256'(m_t[s]));
                  check(wb_line == m_d[s], "R7", "write-back line", wb_line, m_d[s]);
               end
            end
            mstore(s, et, ed, edy);
         end else begin
            check(!wb_valid, "R8", "no write-back without displaced line", 256'(wb_valid), 256'd0);
         end
      end
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      check(!rsp_hit && !rsp_miss && !wb_valid, "R2", "silent idle cycle",
            {253'd0, rsp_hit, rsp_miss, wb_valid}, 256'd0);
   endtask

   task automatic do_flush(input bit with_req, input logic [TAG_W-1:0] t);
      flush = 1'b1; req_valid = with_req; req_tag = t;
      @(negedge clk);
      flush = 1'b0; req_valid = 1'b0;
      check(!rsp_hit && !rsp_miss && !wb_valid, "R9", "flush gives no response",
            {253'd0, rsp_hit, rsp_miss, wb_valid}, 256'd0);
      for (int i = 0; i < NE; i++) m_v[i] = 1'b0;
   endtask

   function automatic logic [TAG_W-1:0] pick_evict(input logic [TAG_W-1:0] t);
      logic [TAG_W-1:0] c;
      for (int k = 0; k < 64; k++) begin
         c = pool[$urandom_range(0, POOL - 1)];
         if (c != t && mfind(c) < 0) return c;
      end
      return t ^ 27'h4000000;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < POOL; i++) pool[i] = TAG_W'($urandom) ^ TAG_W'(i * 977);
      for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_st[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: nothing signalled after reset
      check(!rsp_hit && !rsp_miss && !wb_valid, "R1", "outputs after reset",
            {253'd0, rsp_hit, rsp_miss, wb_valid}, 256'd0);
      idle_cycle();
      // R1/R8: empty buffer misses, nothing stored
      lookup(pool[0], 1'b0, '0, 1'b0);
      lookup(pool[0], 1'b0, '0, 1'b0);
      // R6: fill all free entries; first one dirty, second clean
      lookup(pool[1], 1'b1, pool[2], 1'b1);
      lookup(pool[1], 1'b1, pool[3], 1'b0);
      lookup(pool[1], 1'b1, pool[4], 1'b1);
      lookup(pool[1], 1'b1, pool[5], 1'b0);
      // R4: swap on hit, then find the swapped-in line
      lookup(pool[4], 1'b1, pool[6], 1'b1);
      lookup(pool[6], 1'b1, pool[4], 1'b0);
      // R7: full buffer, oldest (dirty pool[2]) pushed out, then clean pool[3]
      lookup(pool[7], 1'b1, pool[8], 1'b0);
      lookup(pool[7], 1'b1, pool[9], 1'b1);
      // R4: hit without displaced line empties the entry
      lookup(pool[8], 1'b0, '0, 1'b0);
      lookup(pool[8], 1'b0, '0, 1'b0);
      idle_cycle();
      // R9: flush with a request in the same cycle
      do_flush(1'b1, pool[9]);
      lookup(pool[9], 1'b0, '0, 1'b0);
      lookup(pool[5], 1'b1, pool[10], 1'b1);
      // random mix
      for (int n = 0; n < 600; n++) begin
         int r;
         logic [TAG_W-1:0] t;
         r = $urandom_range(0, 99);
         t = pool[$urandom_range(0, POOL - 1)];
         if (r < 4)       do_flush($urandom_range(0, 1), t);
         else if (r < 12) idle_cycle();
         else if (r < 25) lookup(t, 1'b0, '0, 1'b0);
         else             lookup(t, 1'b1, pick_evict(t), 1'($urandom_range(0, 1)));
      end
      idle_cycle();
      finish_run();
   end
endmodule